// File: doc/BRIEF.md
# Clipped Affine Register-Mapped Accelerator

This block computes one scalar result, y = max(0, a*x + b), for signed 32-bit operands. A host reaches it only through an AXI4-Lite slave port. The host first writes the three operand registers. It then sets the launch bit in the control register. Completion can be detected in two ways: by polling the control register for the done flag, or by waiting for the level interrupt output. Once complete, the host reads the result register.

The product is formed at full double width and then pipelined through a parameterised number of register stages. The addend is applied to the low word of the product. The sign of that 32-bit sum decides whether the result is replaced by zero. The operands are captured when a job launches, so the host may reload the inputs while a job is still running without disturbing it.

Register word map (byte offsets):

- 0x00: control
- 0x04: global interrupt enable
- 0x08: interrupt enable
- 0x0C: interrupt status
- 0x10: x
- 0x18: a
- 0x20: b
- 0x28: y

Top module: `clip_affine_axil`

## Requirements
- R1: The value read from y (0x28) is the low 32 bits of (a*x + b) in two's complement when bit 31 of that sum is 0, and 0 when bit 31 is 1. The operands are those held in x (0x10), a (0x18) and b (0x20) when the job launched.
- R2: A job launches at the clock edge that accepts a write to 0x00 with bit0 = 1 while the block is idle. The done event (the done flag and the interrupt status bit0) becomes visible exactly MUL_STAGES+1 clock edges after that edge, and not before.
- R3: A read of 0x00 returns bit0 = 0 (launch self-clears), bit1 = done, bit2 = idle and bit3 = ready (ready equals idle). All other bits read 0. Reading 0x00 clears the done flag, so a second read returns bit1 = 0.
- R4: While a job runs, writes to the operand registers are accepted and stored, but the running job uses the captured operands. A launch write during the run is ignored and produces no second completion. Idle reads 0 during the run.
- R5: irq equals bit0 of 0x04 AND bit0 of 0x08 AND bit0 of 0x0C. Status bit0 is set by each done event. Writing 1 to bit0 of 0x0C clears it, and writing 0 leaves it unchanged.
- R6: Every write returns bResp = 0 (OKAY) and every read returns rResp = 0 (OKAY). A read of an unmapped offset returns 0, and writes to y (0x28) have no effect. Once raised, bValid and rValid hold, with rData stable, until accepted.
- R7: The operand registers read back what was written, honouring the byte strobes: wStrb bit n updates bits 8n+7..8n.
- R8: After reset, control reads 0x0000000C, all other registers read 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | ADDR_W | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response (always OKAY) |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | ADDR_W | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | DATA_W | Read data |
| rResp | output | 2 | Read response (always OKAY) |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| irq | output | 1 | Level interrupt on job completion |

## Verification
The bench builds the block with MUL_STAGES = 4 rather than the default 2. This stretches each job to five busy cycles. That window is long enough for the bench to issue an operand overwrite and a second launch write before the first job completes, so the operand-capture and launch-while-busy rules of R4 can be driven through the bus. The longer pipeline also shows that the done latency follows the parameter rather than a fixed count. The default DATA_W = 32 and ADDR_W = 6 are kept, which lets the random operands reach full-width products whose low word wraps into the sign bit.

// File: rtl/caf_pkg.sv
`timescale 1ns/1ps
package caf_pkg;
  // Word indices (byte offset / 4) of the mapped registers
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_GIE  = 1;
  localparam int unsigned IDX_IER  = 2;
  localparam int unsigned IDX_ISR  = 3;
  localparam int unsigned IDX_X    = 4;
  localparam int unsigned IDX_A    = 6;
  localparam int unsigned IDX_B    = 8;
  localparam int unsigned IDX_Y    = 10;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // control -> datapath strobes
  typedef struct packed {
    logic launch;
  } cafCmd_t;

  // datapath -> control strobes
  typedef struct packed {
    logic finish;
  } cafEvt_t;
endpackage

// File: rtl/caf_datapath.sv
`timescale 1ns/1ps
module caf_datapath
  import caf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cafCmd_t           cmd,
  input  logic [DATA_W-1:0] opX,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output cafEvt_t           evt,
  output logic [DATA_W-1:0] yOut
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned LAST   = MUL_STAGES - 1;

  logic signed [PROD_W-1:0] mulFull;
  logic [PROD_W-1:0]        prodPipe [MUL_STAGES];
  logic [DATA_W-1:0]        addPipe  [MUL_STAGES];
  logic [MUL_STAGES-1:0]    vldPipe;
  logic [DATA_W-1:0]        sumLow;
  logic [DATA_W-1:0]        clipped;
  logic                     finishQ;

  assign mulFull = PROD_W'(signed'(opA)) * PROD_W'(signed'(opX));

  // first stage captures the operands at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodPipe[0] <= '0;
      addPipe[0]  <= '0;
      vldPipe[0]  <= 1'b0;
    end else begin
      vldPipe[0] <= cmd.launch;
      if (cmd.launch) begin
        prodPipe[0] <= mulFull;
        addPipe[0]  <= opB;
      end
    end
  end

  // remaining multiply stages carry the product forward
  for (genvar gi = 1; gi < MUL_STAGES; gi++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodPipe[gi] <= '0;
        addPipe[gi]  <= '0;
        vldPipe[gi]  <= 1'b0;
      end else begin
        vldPipe[gi] <= vldPipe[gi-1];
        if (vldPipe[gi-1]) begin
          prodPipe[gi] <= prodPipe[gi-1];
          addPipe[gi]  <= addPipe[gi-1];
        end
      end
    end
  end

  // add on the low word, then clip on its sign
  assign sumLow  = prodPipe[LAST][DATA_W-1:0] + addPipe[LAST];
  assign clipped = sumLow[DATA_W-1] ? '0 : sumLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yOut    <= '0;
      finishQ <= 1'b0;
    end else begin
      finishQ <= vldPipe[LAST];
      if (vldPipe[LAST]) yOut <= clipped;
    end
  end

  assign evt.finish = finishQ;

  logic unusedHigh;
  assign unusedHigh = ^prodPipe[LAST][PROD_W-1:DATA_W];
endmodule

// File: rtl/caf_ctrl.sv
`timescale 1ns/1ps
module caf_ctrl
  import caf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady,
  output logic                irq,
  output cafCmd_t             cmd,
  input  cafEvt_t             evt,
  input  logic [DATA_W-1:0]   yIn,
  output logic [DATA_W-1:0]   opX,
  output logic [DATA_W-1:0]   opA,
  output logic [DATA_W-1:0]   opB,
  output logic                busy
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0] wIdx, rIdx;
  logic             wrFire, rdFire;
  logic             doneFlag, gieBit, ierBit, isrBit;
  logic             isrClr, ctrlRead;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] res;
    res = oldVal;
    for (int i = 0; i < STRB_W; i++)
      if (strb[i]) res[8*i +: 8] = newVal[8*i +: 8];
    return res;
  endfunction

  // write channel: address and data taken together
  assign wIdx    = awAddr[ADDR_W-1:2];
  assign wrFire  = awValid && wValid && !bValid;
  assign awReady = wrFire;
  assign wReady  = wrFire;
  assign bResp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rstN) bValid <= 1'b0;
    else if (wrFire) bValid <= 1'b1;
    else if (bReady) bValid <= 1'b0;
  end

  // operand and enable registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opX    <= '0;
      opA    <= '0;
      opB    <= '0;
      gieBit <= 1'b0;
      ierBit <= 1'b0;
    end else if (wrFire) begin
      case (wIdx)
        IDX_W'(IDX_X):   opX <= mergeBytes(opX, wData, wStrb);
        IDX_W'(IDX_A):   opA <= mergeBytes(opA, wData, wStrb);
        IDX_W'(IDX_B):   opB <= mergeBytes(opB, wData, wStrb);
        IDX_W'(IDX_GIE): if (wStrb[0]) gieBit <= wData[0];
        IDX_W'(IDX_IER): if (wStrb[0]) ierBit <= wData[0];
        default: ;
      endcase
    end
  end

  // launch / busy / done handshake
  assign cmd.launch = wrFire && (wIdx == IDX_W'(IDX_CTRL)) && wStrb[0] && wData[0] && !busy;
  assign rIdx       = arAddr[ADDR_W-1:2];
  assign rdFire     = arValid && !rValid;
  assign arReady    = !rValid;
  assign ctrlRead   = rdFire && (rIdx == IDX_W'(IDX_CTRL));
  assign isrClr     = wrFire && (wIdx == IDX_W'(IDX_ISR)) && wStrb[0] && wData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      doneFlag <= 1'b0;
      isrBit   <= 1'b0;
    end else begin
      if (cmd.launch)      busy <= 1'b1;
      else if (evt.finish) busy <= 1'b0;

      if (evt.finish)      doneFlag <= 1'b1;
      else if (cmd.launch || ctrlRead) doneFlag <= 1'b0;

      isrBit <= evt.finish || (isrBit && !isrClr);
    end
  end

  assign irq = gieBit && ierBit && isrBit;

  // read channel
  function automatic logic [DATA_W-1:0] readMux(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (idx)
      IDX_W'(IDX_CTRL): v[3:0] = {!busy, !busy, doneFlag, 1'b0};
      IDX_W'(IDX_GIE):  v[0]   = gieBit;
      IDX_W'(IDX_IER):  v[0]   = ierBit;
      IDX_W'(IDX_ISR):  v[0]   = isrBit;
      IDX_W'(IDX_X):    v      = opX;
      IDX_W'(IDX_A):    v      = opA;
      IDX_W'(IDX_B):    v      = opB;
      IDX_W'(IDX_Y):    v      = yIn;
      default:          v      = '0;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdFire) begin
      rValid <= 1'b1;
      rData  <= readMux(rIdx);
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end

  assign rResp = RESP_OKAY;

  logic unusedAddr;
  assign unusedAddr = ^{awAddr[1:0], arAddr[1:0]};
endmodule

// File: rtl/clip_affine_axil.sv
`timescale 1ns/1ps
module clip_affine_axil
  import caf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned MUL_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady,
  output logic                irq
);
  cafCmd_t           cmd;
  cafEvt_t           evt;
  logic [DATA_W-1:0] opX, opA, opB, yVal;
  logic              busyTap, launchTap, finishTap;

  caf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .irq(irq), .cmd(cmd), .evt(evt), .yIn(yVal),
    .opX(opX), .opA(opA), .opB(opB), .busy(busyTap)
  );

  caf_datapath #(.DATA_W(DATA_W), .MUL_STAGES(MUL_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .opX(opX), .opA(opA), .opB(opB),
    .evt(evt), .yOut(yVal)
  );

  assign launchTap = cmd.launch;
  assign finishTap = evt.finish;
endmodule

// File: rtl/caf_checker.sv
`timescale 1ns/1ps
module caf_checker #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MUL_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              launch,
  input logic              finish,
  input logic              busy,
  input logic [DATA_W-1:0] yVal,
  input logic [1:0]        bResp,
  input logic              bValid,
  input logic              bReady,
  input logic [1:0]        rResp,
  input logic              rValid,
  input logic              rReady,
  input logic [DATA_W-1:0] rData
);
  localparam int unsigned CNT_W = $clog2(MUL_STAGES + 3);
  logic [CNT_W-1:0] sinceLaunch;

  always_ff @(posedge clk) begin
    if (!rstN) sinceLaunch <= '0;
    else if (launch) sinceLaunch <= CNT_W'(1);
    else if (finish) sinceLaunch <= '0;
    else if (sinceLaunch != '0) sinceLaunch <= sinceLaunch + CNT_W'(1);
  end

  AST_FINISH_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    finish |-> (sinceLaunch == CNT_W'(MUL_STAGES + 1))); // R2
  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy); // R2
  AST_FINISH_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy); // R4
  AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    finish |-> !yVal[DATA_W-1]); // R1
  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    (bValid |-> bResp == 2'b00) and (rValid |-> rResp == 2'b00)); // R6
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData))); // R6
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid); // R6
endmodule

bind clip_affine_axil caf_checker #(.DATA_W(DATA_W), .MUL_STAGES(MUL_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .launch(launchTap), .finish(finishTap),
  .busy(busyTap), .yVal(yVal),
  .bResp(bResp), .bValid(bValid), .bReady(bReady),
  .rResp(rResp), .rValid(rValid), .rReady(rReady), .rData(rData)
);

// File: tb/test_clip_affine_axil.sv
`timescale 1ns/1ps
module test_clip_affine_axil;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned MS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] awAddr = '0, arAddr = '0;
  logic          awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic [DW-1:0] wData = '0;
  logic [3:0]    wStrb = '0;
  logic          bReady = 1'b1, rReady = 1'b1;
  logic          awReady, wReady, bValid, arReady, rValid, irq;
  logic [1:0]    bResp, rResp;
  logic [DW-1:0] rData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clip_affine_axil #(.DATA_W(DW), .ADDR_W(AW), .MUL_STAGES(MS)) i_clip_affine_axil (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .irq(irq)
  );

  function automatic logic [31:0] model(input logic [31:0] x, a, b);
    longint p;
    logic [31:0] s;
    p = longint'($signed(a)) * longint'($signed(x));
    s = p[31:0] + b;
    return s[31] ? 32'd0 : s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] addr, input logic [31:0] data, input logic [3:0] strb = 4'hF);
    @(negedge clk);
    awAddr = addr; wData = data; wStrb = strb; awValid = 1'b1; wValid = 1'b1;
    #1;
    while (!awReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
    check(bValid && bResp == 2'b00, "R6 bresp", {30'd0, bResp}, 32'd0);
  endtask

  task automatic busRead(input logic [AW-1:0] addr, output logic [31:0] data);
    @(negedge clk);
    arAddr = addr; arValid = 1'b1;
    #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0;
    data = rData;
    check(rValid && rResp == 2'b00, "R6 rresp", {30'd0, rResp}, 32'd0);
  endtask

  task automatic runJob(input logic [31:0] x, a, b, input string tag);
    logic [31:0] v;
    int n;
    busWrite(6'h10, x);
    busWrite(6'h18, a);
    busWrite(6'h20, b);
    busWrite(6'h00, 32'd1);
    n = 0;
    do begin busRead(6'h00, v); n++; end while (!v[1] && n < 50);
    check(v[1] == 1'b1, "R3 done seen", v, 32'h2);
    busRead(6'h28, v);
    check(v == model(x, a, b), tag, v, model(x, a, b));
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] rx, ra, rb;
    void'($urandom(32'hC1A5));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R8 reset state
    check(irq == 1'b0, "R8 irq", {31'd0, irq}, 32'd0);
    busRead(6'h00, v); check(v == 32'h0000000C, "R8 ctrl", v, 32'hC);
    busRead(6'h10, v); check(v == 0, "R8 x", v, 0);
    busRead(6'h28, v); check(v == 0, "R8 y", v, 0);
    busRead(6'h0C, v); check(v == 0, "R8 isr", v, 0);

    // R7 byte strobes
    busWrite(6'h10, 32'h11223344);
    busWrite(6'h10, 32'hAABBCCDD, 4'b0101);
    busRead(6'h10, v); check(v == 32'h11BB33DD, "R7 strobe", v, 32'h11BB33DD);
    busWrite(6'h18, 32'hDEADBEEF);
    busRead(6'h18, v); check(v == 32'hDEADBEEF, "R7 a readback", v, 32'hDEADBEEF);

    // R6 unmapped and read-only
    busRead(6'h2C, v); check(v == 0, "R6 unmapped", v, 0);
    busRead(6'h3C, v); check(v == 0, "R6 unmapped high", v, 0);
    busWrite(6'h28, 32'h12345678);
    busRead(6'h28, v); check(v == 0, "R6 y read-only", v, 0);

    // R1 directed corners
    runJob(32'd7, 32'd3, 32'd5, "R1 small");
    runJob(32'd5, 32'hFFFFFFFF, 32'd5, "R1 zero sum");
    runJob(32'd0, 32'd0, 32'hFFFFFFFF, "R1 negative clip");
    runJob(32'h00008000, 32'h00010000, 32'd0, "R1 wrap to sign");
    runJob(32'h00010000, 32'h00010000, 32'd9, "R1 wrap to zero");
    runJob(32'h7FFFFFFF, 32'd1, 32'd1, "R1 add overflow");
    runJob(32'hFFFFFFFD, 32'hFFFFFFFE, 32'd1, "R1 neg times neg");

    // R3 done clears on read
    busWrite(6'h00, 32'd1);
    repeat (MS + 3) @(negedge clk);
    busRead(6'h00, v); check(v == 32'h0000000E, "R3 ctrl done", v, 32'hE);
    busRead(6'h00, v); check(v == 32'h0000000C, "R3 done cleared", v, 32'hC);

    // R5 interrupt gating
    busWrite(6'h0C, 32'd1);
    busWrite(6'h08, 32'd1);
    busWrite(6'h04, 32'd0);
    busWrite(6'h00, 32'd1);
    repeat (MS + 3) @(negedge clk);
    check(irq == 1'b0, "R5 gie off", {31'd0, irq}, 0);
    busRead(6'h0C, v); check(v == 1, "R5 isr set", v, 1);
    busWrite(6'h04, 32'd1);
    check(irq == 1'b1, "R5 irq on", {31'd0, irq}, 1);
    busWrite(6'h0C, 32'd0);
    check(irq == 1'b1, "R5 write0 keeps", {31'd0, irq}, 1);
    busWrite(6'h0C, 32'd1);
    check(irq == 1'b0, "R5 w1c", {31'd0, irq}, 0);

    // R2 latency measured on irq
    busWrite(6'h00, 32'd1);
    repeat (MS) @(negedge clk);
    check(irq == 1'b0, "R2 not early", {31'd0, irq}, 0);
    @(negedge clk);
    check(irq == 1'b1, "R2 on time", {31'd1, irq}, 1);
    busWrite(6'h0C, 32'd1);
    busRead(6'h00, v);

    // R4 operand capture and launch while busy
    busWrite(6'h10, 32'd10);
    busWrite(6'h18, 32'd20);
    busWrite(6'h20, 32'd30);
    busWrite(6'h00, 32'd1);
    busWrite(6'h10, 32'd99);
    busWrite(6'h00, 32'd1);
    busRead(6'h00, v); check(v[2] == 1'b0 || v[1] == 1'b1, "R4 idle low in run", v, 32'h0);
    repeat (MS + 3) @(negedge clk);
    busRead(6'h28, v); check(v == 32'd230, "R4 captured operands", v, 32'd230);
    busRead(6'h10, v); check(v == 32'd99, "R4 write stored", v, 32'd99);
    busWrite(6'h0C, 32'd1);
    repeat (MS + 6) @(negedge clk);
    check(irq == 1'b0, "R4 no second job", {31'd0, irq}, 0);
    busRead(6'h00, v); check(v == 32'h0000000C, "R4 idle after", v, 32'hC);

    // R1 random operands
    for (int i = 0; i < 60; i++) begin
      rx = $urandom; ra = $urandom; rb = $urandom;
      if (i % 2 == 0) begin
        rx = {{24{rx[7]}}, rx[7:0]};
        ra = {{24{ra[7]}}, ra[7:0]};
        rb = {{20{rb[11]}}, rb[11:0]};
      end
      runJob(rx, ra, rb, "R1 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule